// File: doc/BRIEF.md
# LCD common scan sequencer

This block sequences the row (common) lines of an 80-output LCD driver and places column (segment) data on the remaining outputs. A two-bit mode input sets how many of the 80 outputs carry segment data and how many act as commons. One mode makes every output a common. Two modes split the outputs into a low segment field and a high common field. The fourth mode is a test setting that turns every output off.

Each row-advance strobe moves the single active common to the next line and captures a new segment word for that row. After the last common of the current mode, the active common wraps back to the first. In master mode the block makes the strobe itself from a programmable divider of the clock, drives it on its strobe pin and enables that pin's driver. In slave mode the strobe pin's driver is off, and the block advances on each rising edge of a strobe that an external master supplies.

An active-high standby input stops all activity. While it is high, every output sits at the non-select level and the sequence returns to the first common.

Top module: `lcd_scan_seq`

## Requirements
- R1: While `standby_i` is 1, `out_o` is all zeros, `row_load_o` and `row_load_oe_o` are 0, and the active common and the segment latch are cleared, so no strobe pulses occur.
- R2: With `mode_i`=2'b01, all 80 outputs are commons. Common n (counting from 1) is `out_o[n-1]`, and exactly one output is 1 at any time.
- R3: With `mode_i`=2'b10, `out_o[31:0]` equals bits [31:0] of the segment latch, and `out_o[79:32]` carry commons 1 to 48, with common 1 on `out_o[32]`. Bits [47:32] of `seg_data_i` have no effect on the outputs in this mode.
- R4: With `mode_i`=2'b11, `out_o[47:0]` equals bits [47:0] of the segment latch, and `out_o[79:48]` carry commons 1 to 32, with common 1 on `out_o[48]`.
- R5: With `mode_i`=2'b00 (test), `out_o` is all zeros and the active common is held at common 1. On leaving test mode, common 1 is selected at once.
- R6: With `master_i`=1 and not in standby, `row_load_oe_o` is 1 and `row_load_o` is a one-cycle pulse once every `div_i`+1 clock cycles (for `div_i`>=1). The first pulse comes `div_i`+1 cycles after standby is released.
- R7: With `master_i`=0, `row_load_oe_o` and `row_load_o` are 0. The block advances once on each clock edge at which `row_load_i` is 1 after having been 0; holding `row_load_i` high gives no further advance.
- R8: At every strobe, the active common moves from common n to common n+1, or from the last common of the current mode back to common 1. At the same edge, the segment latch captures `seg_data_i`.
- R9: After standby is released, common 1 is active and the segment latch reads zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | 1 = standby, 0 = run |
| master_i | input | 1 | 1 = make the strobe, 0 = follow it |
| mode_i | input | 2 | Output split: 00 test, 01 80 commons, 10 32 segments + 48 commons, 11 48 segments + 32 commons |
| div_i | input | 16 | Strobe period minus one, in clock cycles (master mode) |
| seg_data_i | input | 48 | Segment word captured at each strobe |
| row_load_i | input | 1 | Strobe from an external master (slave mode) |
| row_load_o | output | 1 | Strobe driven in master mode |
| row_load_oe_o | output | 1 | Driver enable for the strobe pin |
| out_o | output | 80 | Segment and common outputs |

## Verification
The assertions check four properties on every cycle. Standby and test mode keep the outputs dark. Exactly one common is high whenever the sequence is within range of the mode. Each strobe steps or wraps the common counter, and standby clears that counter. The master pulse lasts one cycle, and no strobe is driven in slave mode. Only the bench's scenarios can show the rest, because those checks compare the full 80-bit output word against values computed from the mode tables. These are the exact segment-to-output bit placement per mode, the strobe period set by `div_i`, the wrap after the 80th, 48th and 32nd common, single advances on a held slave strobe, and the return to common 1 after standby or test mode.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [1:0] {
        MODE_TEST  = 2'b00,
        MODE_COM80 = 2'b01,
        MODE_SPLIT_A = 2'b10,
        MODE_SPLIT_B = 2'b11
    } scan_mode_e;
endpackage

// File: rtl/lcd_mode_dec.sv
module lcd_mode_dec
    import lcd_scan_pkg::*;
#(
    parameter int NOUT  = 80,
    parameter int SEG_A = 32,
    parameter int SEG_B = 48,
    parameter int CNT_W = $clog2(NOUT + 1)
) (
    input  logic [1:0]       mode_i,
    output logic [CNT_W-1:0] nseg_o,
    output logic [CNT_W-1:0] ncom_o,
    output logic             test_o
);
    localparam logic [CNT_W-1:0] NOUT_C  = CNT_W'(NOUT);
    localparam logic [CNT_W-1:0] SEG_A_C = CNT_W'(SEG_A);
    localparam logic [CNT_W-1:0] SEG_B_C = CNT_W'(SEG_B);

    always_comb begin
        test_o = 1'b0;
        nseg_o = '0;
        unique case (scan_mode_e'(mode_i))
            MODE_TEST:    test_o = 1'b1;
            MODE_COM80:   nseg_o = '0;
            MODE_SPLIT_A: nseg_o = SEG_A_C;
            MODE_SPLIT_B: nseg_o = SEG_B_C;
            default:      test_o = 1'b1;
        endcase
        ncom_o = NOUT_C - nseg_o;
    end
endmodule

// File: rtl/lcd_load_gen.sv
module lcd_load_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             master_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             load_i,
    output logic             strobe_o,
    output logic             load_o,
    output logic             load_oe_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             load;
        logic             prev;
    } lg_state_t;

    lg_state_t st_d, st_q;
    logic      strobe_d;

    always_comb begin
        st_d     = st_q;
        strobe_d = 1'b0;
        if (!run_i) begin
            st_d = '0;
        end else if (master_i) begin
            st_d.prev = 1'b0;
            if (st_q.cnt >= div_i) begin
                st_d.cnt  = '0;
                st_d.load = 1'b1;
                strobe_d  = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.load = 1'b0;
            end
        end else begin
            st_d.cnt  = '0;
            st_d.load = 1'b0;
            strobe_d  = load_i & ~st_q.prev;
            st_d.prev = load_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_o  = strobe_d;
    assign load_o    = st_q.load;
    assign load_oe_o = master_i & run_i;

    // R6: a master pulse lasts one cycle
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && div_i != '0) |=> (!st_q.load || div_i == '0));

    // R7: no strobe is driven in slave mode
    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |=> !st_q.load);

    // R1: standby leaves no pulse behind
    p_stby_no_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !st_q.load);
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq #(
    parameter int CNT_W   = 7,
    parameter int SEG_MAX = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               strobe_i,
    input  logic [CNT_W-1:0]   ncom_i,
    input  logic [SEG_MAX-1:0] seg_data_i,
    output logic [CNT_W-1:0]   row_o,
    output logic [SEG_MAX-1:0] seg_o
);
    typedef struct packed {
        logic [CNT_W-1:0]   row;
        logic [SEG_MAX-1:0] seg;
    } rs_state_t;

    rs_state_t st_d, st_q;
    logic [CNT_W:0] row_inc;

    always_comb begin
        st_d    = st_q;
        row_inc = {1'b0, st_q.row} + 1'b1;
        if (clear_i) begin
            st_d = '0;
        end else if (strobe_i) begin
            st_d.row = (row_inc >= {1'b0, ncom_i}) ? '0 : row_inc[CNT_W-1:0];
            st_d.seg = seg_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o = st_q.row;
    assign seg_o = st_q.seg;

    // R1: standby or test clears the common counter
    p_clear_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.row == '0 && st_q.seg == '0));

    // R8: a strobe steps to the next common
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && strobe_i && ({1'b0, st_q.row} + 1'b1 < {1'b0, ncom_i}))
        |=> st_q.row == $past(st_q.row) + 1'b1);

    // R8: a strobe at the last common wraps to common 1
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && strobe_i && ({1'b0, st_q.row} + 1'b1 >= {1'b0, ncom_i}))
        |=> st_q.row == '0);

    // R8: without a strobe the row holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !strobe_i) |=> $stable(st_q.row));
endmodule

// File: rtl/lcd_out_map.sv
module lcd_out_map #(
    parameter int NOUT    = 80,
    parameter int SEG_MAX = 48,
    parameter int CNT_W   = 7
) (
    input  logic               active_i,
    input  logic [CNT_W-1:0]   nseg_i,
    input  logic [CNT_W-1:0]   row_i,
    input  logic [SEG_MAX-1:0] seg_i,
    output logic [NOUT-1:0]    com_o,
    output logic [NOUT-1:0]    out_o
);
    logic [CNT_W:0]   com_pos;
    logic [NOUT-1:0]  seg_vec;

    assign com_pos = {1'b0, row_i} + {1'b0, nseg_i};

    for (genvar k = 0; k < NOUT; k++) begin : g_bit
        localparam logic [CNT_W:0] POS = (CNT_W + 1)'(k);
        assign com_o[k] = (POS >= {1'b0, nseg_i}) && (com_pos == POS);
        if (k < SEG_MAX) begin : g_seg
            assign seg_vec[k] = (POS < {1'b0, nseg_i}) && seg_i[k];
        end else begin : g_noseg
            assign seg_vec[k] = 1'b0;
        end
    end

    assign out_o = active_i ? (com_o | seg_vec) : '0;
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq #(
    parameter int NOUT    = 80,
    parameter int SEG_A   = 32,
    parameter int SEG_B   = 48,
    parameter int DIV_W   = 16,
    parameter int SEG_MAX = SEG_B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby_i,
    input  logic               master_i,
    input  logic [1:0]         mode_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [SEG_MAX-1:0] seg_data_i,
    input  logic               row_load_i,
    output logic               row_load_o,
    output logic               row_load_oe_o,
    output logic [NOUT-1:0]    out_o
);
    localparam int CNT_W = $clog2(NOUT + 1);

    logic               run;
    logic               test_mode;
    logic               strobe;
    logic [CNT_W-1:0]   nseg, ncom, row;
    logic [SEG_MAX-1:0] seg_q;
    logic [NOUT-1:0]    com_vec;

    assign run = ~standby_i;

    lcd_mode_dec #(.NOUT(NOUT), .SEG_A(SEG_A), .SEG_B(SEG_B), .CNT_W(CNT_W)) u_dec (
        .mode_i (mode_i),
        .nseg_o (nseg),
        .ncom_o (ncom),
        .test_o (test_mode)
    );

    lcd_load_gen #(.DIV_W(DIV_W)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .master_i  (master_i),
        .div_i     (div_i),
        .load_i    (row_load_i),
        .strobe_o  (strobe),
        .load_o    (row_load_o),
        .load_oe_o (row_load_oe_o)
    );

    lcd_row_seq #(.CNT_W(CNT_W), .SEG_MAX(SEG_MAX)) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (standby_i | test_mode),
        .strobe_i   (strobe),
        .ncom_i     (ncom),
        .seg_data_i (seg_data_i),
        .row_o      (row),
        .seg_o      (seg_q)
    );

    lcd_out_map #(.NOUT(NOUT), .SEG_MAX(SEG_MAX), .CNT_W(CNT_W)) u_map (
        .active_i (run & ~test_mode),
        .nseg_i   (nseg),
        .row_i    (row),
        .seg_i    (seg_q),
        .com_o    (com_vec),
        .out_o    (out_o)
    );

    // R1: standby keeps every output at non-select
    p_stby_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |-> out_o == '0);

    // R5: test mode keeps every output at non-select
    p_test_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> out_o == '0);

    // R2: one common is active while the row is in range
    p_one_com_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !test_mode && row < ncom) |-> $countones(out_o & com_vec) == 1);
endmodule

// File: tb/lcd_scan_seq_tb.sv
module lcd_scan_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NOUT = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b1;
    logic        master_i = 1'b1;
    logic [1:0]  mode_i = 2'b01;
    logic [15:0] div_i = 16'd3;
    logic [47:0] seg_data_i = '0;
    logic        row_load_i = 1'b0;
    logic        row_load_o, row_load_oe_o;
    logic [79:0] out_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .master_i(master_i),
        .mode_i(mode_i), .div_i(div_i), .seg_data_i(seg_data_i),
        .row_load_i(row_load_i), .row_load_o(row_load_o),
        .row_load_oe_o(row_load_oe_o), .out_o(out_o)
    );

    function automatic logic [79:0] exp_out(input logic [1:0] m, input int r,
                                            input logic [47:0] s);
        logic [79:0] v;
        case (m)
            2'b01:   v = 80'(1) << r;
            2'b10:   v = {48'b0, s[31:0]} | (80'(1) << (32 + r));
            2'b11:   v = {32'b0, s} | (80'(1) << (48 + r));
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter_standby();
        standby_i = 1'b1;
        step(2);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1 out in standby", out_o, '0);
        chk("R1 load pin in standby", {78'b0, row_load_oe_o, row_load_o}, '0);
    endtask

    task automatic t_com80_master();
        master_i = 1'b1; mode_i = 2'b01; div_i = 16'd3;
        enter_standby();
        standby_i = 1'b0; #1;
        chk("R9 common 1 after release", out_o, exp_out(2'b01, 0, '0));
        chk("R6 driver enabled", 80'(row_load_oe_o), 80'(1));
        for (int i = 1; i <= NOUT; i++) begin
            @(negedge clk); step(2);
            chk("R6 no pulse before period", 80'(row_load_o), '0);
            step(1);
            chk("R6 pulse at period", 80'(row_load_o), 80'(1));
            chk("R2 R8 common step/wrap", out_o, exp_out(2'b01, i % NOUT, '0));
        end
        step(1);
        chk("R6 pulse one cycle", 80'(row_load_o), '0);
    endtask

    task automatic t_splitA_slave();
        logic [47:0] s;
        master_i = 1'b0; mode_i = 2'b10; row_load_i = 1'b0;
        enter_standby();
        standby_i = 1'b0; #1;
        chk("R7 driver off", {78'b0, row_load_oe_o, row_load_o}, '0);
        chk("R9 segments zero, common 1", out_o, exp_out(2'b10, 0, '0));
        for (int i = 1; i <= 48; i++) begin
            s = {16'hFFFF, 32'(i * 32'h0101_0101) ^ 32'hA5A5_5A5A};
            seg_data_i = s; row_load_i = 1'b1;
            step(1);
            chk("R3 R8 slave advance", out_o, exp_out(2'b10, i % 48, s));
            if (i % 2 == 1) begin
                seg_data_i = ~s;
                step(1);
                chk("R7 held strobe no advance", out_o, exp_out(2'b10, i % 48, s));
            end
            row_load_i = 1'b0;
            step(1);
            chk("R7 no advance on fall", out_o, exp_out(2'b10, i % 48, s));
        end
        chk("R7 no drive in slave", 80'(row_load_o), '0);
    endtask

    task automatic t_splitB_master();
        logic [47:0] s;
        master_i = 1'b1; mode_i = 2'b11; div_i = 16'd1;
        enter_standby();
        standby_i = 1'b0;
        for (int i = 1; i <= 33; i++) begin
            s = {16'(i * 16'h3C1), 32'(i) * 32'h1357_9BDF};
            seg_data_i = s;
            step(2);
            chk("R6 pulse every 2", 80'(row_load_o), 80'(1));
            chk("R4 R8 split B", out_o, exp_out(2'b11, i % 32, s));
        end
    endtask

    task automatic t_test_mode();
        master_i = 1'b1; mode_i = 2'b00; div_i = 16'd2;
        enter_standby();
        standby_i = 1'b0; seg_data_i = '1;
        for (int i = 0; i < 4; i++) begin
            step(2);
            chk("R5 test mode dark", out_o, '0);
        end
        mode_i = 2'b01; #1;
        chk("R5 common 1 on leaving test", out_o, exp_out(2'b01, 0, '0));
    endtask

    task automatic t_standby_mid();
        master_i = 1'b1; mode_i = 2'b01; div_i = 16'd1;
        enter_standby();
        standby_i = 1'b0;
        step(6);
        chk("R8 at common 4", out_o, exp_out(2'b01, 3, '0));
        standby_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R1 dark and silent", {out_o[77:0], row_load_oe_o, row_load_o},
                '0);
        end
        standby_i = 1'b0; #1;
        chk("R1 R9 restart at common 1", out_o, exp_out(2'b01, 0, '0));
        step(2);
        chk("R6 first pulse after release", 80'(row_load_o), 80'(1));
        chk("R8 common 2 after first pulse", out_o, exp_out(2'b01, 1, '0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        t_reset();
        t_com80_master();
        t_splitA_slave();
        t_splitB_master();
        t_test_mode();
        t_standby_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule